// File: doc/BRIEF.md
# Two-Source Four-Lane Vector Swizzle

This block permutes the lanes of a four-element vector whose lanes are named x, y, z and w. Each destination lane takes any one element from either of two source vectors. Which element and which source comes from a selector word supplied as a register operand, so one operation covers every pattern without changing the operation itself.

A four-bit write mask picks the destination lanes that are written. A lane with its mask bit clear passes through the prior destination value unchanged. Suppose the prior destination is also fed in as the second source. A partial write such as `dest.yw = src.zy` then works either way: the masked lanes are left alone, or they select their own old element.

The merged result goes into an output register one clock after a valid/ready transfer is accepted. It stays there until the consumer takes it.

Top module: `lane_swizzle`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `out_valid` low and `out_data` all zeros.
- R2: Lane i (x=0, y=1, z=2, w=3) occupies bits [32i+31:32i] of every vector. Its selector field is `sel[3i+2:3i]`, and its mask bit is `wmask[i]`. For example, selector fields x=4, y=2, z=6, w=1 with mask 4'b1010 and `src_b` equal to `dest_old` write `dest.yw` from `src_a.zy`.
- R3: A selector field whose top bit is 0 makes the lane take `src_a` lane number (field bits [1:0]).
- R4: A selector field whose top bit is 1 makes the lane take `src_b` lane number (field bits [1:0]).
- R5: A lane whose mask bit is 0 outputs the `dest_old` lane in the same position, whatever its selector field says.
- R6: With `wmask` equal to 0, the result equals `dest_old` exactly.
- R7: A transfer is accepted when `in_valid` and `in_ready` are both high at a clock edge. After that edge, `out_valid` is high and `out_data` holds the merged result.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged, and `in_ready` is low.
- R9: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. A new transfer can therefore be accepted in the same cycle that the previous result is taken.
- R10: When the result is taken and no new transfer is accepted, `out_valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Unit can take operands |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| sel | input | 12 | Per-lane selector, 3 bits per lane |
| wmask | input | 4 | Destination lane write mask, bit 0 = x |
| dest_old | input | 128 | Prior destination value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | 128 | Registered merged result |

## Verification
The bench reproduces the `dest.yw = src.zy` partial write with an explicitly computed answer. A design with reversed lane or field order would scatter elements into the wrong lanes. It drives mask zero with selectors that point away from every lane, which catches a merge that ignores the mask. It holds `out_ready` low while offering new operands, so that a register which overwrote a stalled result or dropped it would show. Random runs with gaps on both sides check back-to-back acceptance on the draining cycle. A design that asserted ready only when empty would be caught there.

// File: rtl/lane_swizzle.sv
module lane_swizzle #(
  parameter int LANE_W = 32,
  parameter int LANES  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [LANE_W*LANES-1:0]       src_a,
  input  logic [LANE_W*LANES-1:0]       src_b,
  input  logic [($clog2(LANES)+1)*LANES-1:0] sel,
  input  logic [LANES-1:0]              wmask,
  input  logic [LANE_W*LANES-1:0]       dest_old,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [LANE_W*LANES-1:0]       out_data
);
  localparam int IDX_W = $clog2(LANES);
  localparam int FLD_W = IDX_W + 1;
  localparam int VEC_W = LANE_W * LANES;

  logic [VEC_W-1:0] merged;
  logic             take;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [FLD_W-1:0] fld;
    logic [VEC_W-1:0] pool;
    logic [LANE_W-1:0] picked;
    assign fld    = sel[g*FLD_W +: FLD_W];
    assign pool   = fld[IDX_W] ? src_b : src_a;
    assign picked = pool[fld[IDX_W-1:0]*LANE_W +: LANE_W];
    assign merged[g*LANE_W +: LANE_W] = wmask[g] ? picked : dest_old[g*LANE_W +: LANE_W];
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= merged;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0));

  // R7
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  mask_none_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && wmask == '0) |=> (out_data == $past(dest_old)));

  // R10
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: tb/lane_swizzle_test.sv
module lane_swizzle_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst;
  logic         in_valid, in_ready, out_valid, out_ready;
  logic [127:0] src_a, src_b, dest_old, out_data;
  logic [11:0]  sel;
  logic [3:0]   wmask;

  lane_swizzle uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .sel(sel), .wmask(wmask),
    .dest_old(dest_old), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string tag = "R1";

  logic         exp_valid;
  logic [127:0] exp_data;

  function automatic logic [127:0] ref_vec(input logic [127:0] a, input logic [127:0] b,
                                           input logic [11:0] s, input logic [3:0] m,
                                           input logic [127:0] d);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) begin
      int f;
      int idx;
      f   = (s >> (3 * i)) & 7;
      idx = f % 4;
      if (!m[i]) r[i*32 +: 32] = d[i*32 +: 32];
      else if (f >= 4) r[i*32 +: 32] = b[idx*32 +: 32];
      else r[i*32 +: 32] = a[idx*32 +: 32];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_valid <= 1'b0;
      exp_data  <= '0;
    end else if (in_valid && (!exp_valid || out_ready)) begin
      exp_valid <= 1'b1;
      exp_data  <= ref_vec(src_a, src_b, sel, wmask, dest_old);
    end else if (out_ready) begin
      exp_valid <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && exp_valid !== 1'bx) begin
      check((exp_valid && !out_ready) ? "R8" : "R10", {127'd0, out_valid}, {127'd0, exp_valid});
      check("R9", {127'd0, in_ready}, {127'd0, (!exp_valid || out_ready)});
      check(tag, out_data, exp_data);
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic cyc;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [11:0] mk_sel(input int x, input int y, input int z, input int w);
    return {w[2:0], z[2:0], y[2:0], x[2:0]};
  endfunction

  task automatic send(input logic [11:0] s, input logic [3:0] m);
    in_valid = 1'b1;
    sel = s;
    wmask = m;
    cyc();
    in_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    src_a = '0; src_b = '0; dest_old = '0; sel = '0; wmask = '0;
    cyc(); cyc();
    #3;
    // R1: reset state
    check("R1", {127'd0, out_valid}, 128'd0);
    check("R1", out_data, 128'd0);
    rst = 1'b0;
    cyc();

    src_a    = {32'hA000_0003, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000};
    src_b    = {32'hB000_0003, 32'hB000_0002, 32'hB000_0001, 32'hB000_0000};
    dest_old = {32'hD000_0003, 32'hD000_0002, 32'hD000_0001, 32'hD000_0000};

    tag = "R3";
    send(mk_sel(3, 2, 1, 0), 4'b1111);
    cyc();
    tag = "R4";
    send(mk_sel(4, 7, 5, 6), 4'b1111);
    tag = "R5";
    send(mk_sel(7, 7, 7, 7), 4'b0101);
    tag = "R6";
    send(mk_sel(1, 6, 3, 4), 4'b0000);
    #3;
    check("R6", out_data, dest_old);
    cyc();

    // R2: dest.yw = src.zy with the old destination as second source
    tag = "R2";
    src_b = dest_old;
    send(mk_sel(4, 2, 6, 1), 4'b1010);
    #3;
    check("R2", out_data, {src_a[63:32], dest_old[95:64], src_a[95:64], dest_old[31:0]});
    cyc();

    // R8: stall holds result and refuses new operands
    tag = "R8";
    out_ready = 1'b0;
    send(mk_sel(0, 0, 0, 0), 4'b1111);
    in_valid = 1'b1; sel = mk_sel(5, 5, 5, 5);
    cyc(); cyc(); cyc();
    #3;
    check("R8", out_data, {4{32'hA000_0000}});
    out_ready = 1'b1;
    cyc();
    // R9: accepted while draining; then R10 drain
    tag = "R9";
    in_valid = 1'b0;
    cyc(); cyc();

    tag = "R7";
    for (int n = 0; n < 400; n++) begin
      src_a = {$urandom, $urandom, $urandom, $urandom};
      src_b = {$urandom, $urandom, $urandom, $urandom};
      dest_old = {$urandom, $urandom, $urandom, $urandom};
      sel = 12'($urandom);
      wmask = 4'($urandom);
      in_valid = ($urandom % 4) != 0;
      out_ready = ($urandom % 3) != 0;
      cyc();
    end
    in_valid = 1'b0; out_ready = 1'b1;
    cyc(); cyc();
    finish_run();
  end
endmodule